// File: doc/BRIEF.md
# Replicated Memory Write Transmit Filter

This block takes host writes aimed at a node's local copy of replicated shared memory and turns each one into an outgoing ring message. A write may carry byte enables. The block merges those bytes into the current 32-bit word, because the ring only ever carries whole words. It can drop writes that would not change the stored word. It tags each message with an interrupt flag. It then queues the message in a transmit FIFO that a serializer drains.

The local copy of the word is updated in one of two ways. In immediate mode it is written on the same edge the write is accepted. In deferred mode it is written only when the node's own message comes back around the ring. Deferred words wait in a small in-order tracking queue. When the transmit FIFO or the tracking queue is full, the block stalls the host by holding its ready signal low.

Top module: `rmw_tx_filter`

## Requirements
- R1: A write with byte enables `wr_be` (bit n covers data bits 8n+7..8n) forms a merged word: enabled bytes come from `wr_data` and the other bytes keep the stored word's value. The whole merged word is the one transmitted and stored.
- R2: With `cfg_filt_en`=1 and a word address at or above `LOW_WORDS`, a merged word equal to the stored word produces no message and no memory update. This includes a partial write whose bytes all match.
- R3: Below `LOW_WORDS`, filtering takes effect only when both `cfg_filt_en` and `cfg_filt_low` are 1. `cfg_filt_low` by itself has no effect.
- R4: With `cfg_filt_en`=0, every accepted write is transmitted, even if the value is unchanged.
- R5: `tx_valid` is asserted only while `cfg_tx_en`=1 and the transmit FIFO holds an entry. Entries written while `cfg_tx_en`=0 are held and leave later, in order.
- R6: `tx_irq` = `cfg_net_irq_en` AND (`cfg_irq_override` OR the write's `wr_word_irq`).
- R7: Messages leave in acceptance order. `tx_not_empty` reflects a non-empty FIFO. `tx_almost_full` is set at 7/8 of `TXQ_DEPTH` entries or more. `tx_full` is set at `TXQ_DEPTH` entries.
- R8: While the transmit FIFO is full, `wr_ready`=0. A write held at the port is accepted once space frees, and it is not lost.
- R9: When `cfg_update_mode` is any value other than 2'b11, a transmitted write updates local memory on its accept edge. The new value is visible on `rd_data` from the next cycle.
- R10: When `cfg_update_mode`=2'b11, a transmitted write leaves local memory unchanged. The word is written when a return arrives with `ret_src_id`=`node_id` and `ret_addr` equal to the oldest pending address. Pending words complete in order.
- R11: A return with a different `ret_src_id`, or with an address other than the oldest pending one, changes nothing.
- R12: In deferred mode, with `WQ_DEPTH` words pending, `wr_ready`=0 until a matching return frees a slot.
- R13: After reset the transmit FIFO and the tracking queue are empty. `tx_valid`, `tx_full`, `tx_not_empty` and `tx_almost_full` are 0 and `wr_ready` is 1. Memory contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Lets queued messages leave |
| cfg_filt_en | input | 1 | Redundant-write filter enable |
| cfg_filt_low | input | 1 | Extends filtering to words below LOW_WORDS |
| cfg_net_irq_en | input | 1 | Global outgoing interrupt enable |
| cfg_irq_override | input | 1 | Tags every message with interrupt when enabled |
| cfg_update_mode | input | 2 | 2'b11 defers local update until own return |
| node_id | input | ID_W | This node's ring identifier |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accepted when high with wr_valid |
| wr_addr | input | AW | Word address |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| wr_word_irq | input | 1 | Per-word transmit-interrupt control bit |
| rd_addr | input | AW | Local memory read address |
| rd_data | output | 32 | Local memory read data |
| tx_valid | output | 1 | Message available |
| tx_ready | input | 1 | Serializer takes message |
| tx_addr | output | AW | Message word address |
| tx_data | output | 32 | Message word |
| tx_irq | output | 1 | Message interrupt flag |
| tx_full | output | 1 | Transmit FIFO full |
| tx_not_empty | output | 1 | Transmit FIFO holds an entry |
| tx_almost_full | output | 1 | Transmit FIFO at 7/8 or above |
| ret_valid | input | 1 | Message returning from ring |
| ret_src_id | input | ID_W | Originator ID of returning message |
| ret_addr | input | AW | Word address of returning message |

## Verification
A wrong stored word shows on `rd_data` within one cycle. It also shows up later as a wrongly merged partial write or a wrongly filtered write, visible as a missing or extra message. A corrupted FIFO count or pointer shows as out-of-order or repeated words at the transmit port, or as a flag or `wr_ready` out of step with the number of writes. Lost tracking-queue state shows as memory that never updates after a matching return, or as a host stall that never clears.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int BYTES = 4;
  localparam int WORD_W = 8 * BYTES;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTES-1:0] be_t;
  localparam logic [1:0] UPD_DEFER = 2'b11;
endpackage

// File: rtl/rmw_write_eval.sv
module rmw_write_eval
  import rmw_pkg::*;
#(
  parameter int AW = 11,
  parameter int LOW_WORDS = 1024
) (
  input  logic [AW-1:0] addr,
  input  word_t         old_word,
  input  word_t         new_data,
  input  be_t           be,
  input  logic          filt_en,
  input  logic          filt_low,
  input  logic          net_irq_en,
  input  logic          irq_override,
  input  logic          word_irq,
  output word_t         merged,
  output logic          send,
  output logic          irq
);
  logic in_low;
  logic filt_active;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = be[b] ? new_data[8*b +: 8] : old_word[8*b +: 8];
  end

  always_comb begin
    in_low      = (addr < AW'(LOW_WORDS));
    filt_active = filt_en && (!in_low || filt_low);
    send        = !filt_active || (merged != old_word);
    irq         = net_irq_en && (irq_override || word_irq);
  end
endmodule

// File: rtl/rmw_fifo.sv
module rmw_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, rd_ptr_n, wr_ptr, wr_ptr_n;
  logic [CW-1:0] cnt_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ptr_n = pop  ? bump(rd_ptr) : rd_ptr;
    wr_ptr_n = push ? bump(wr_ptr) : wr_ptr;
    cnt_n    = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      count  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  assign dout = store[rd_ptr];

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));
  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(count));
endmodule

// File: rtl/rmw_tx_filter.sv
module rmw_tx_filter
  import rmw_pkg::*;
#(
  parameter int AW = 11,
  parameter int LOW_WORDS = 1024,
  parameter int TXQ_DEPTH = 1024,
  parameter int WQ_DEPTH = 4,
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_tx_en,
  input  logic            cfg_filt_en,
  input  logic            cfg_filt_low,
  input  logic            cfg_net_irq_en,
  input  logic            cfg_irq_override,
  input  logic [1:0]      cfg_update_mode,
  input  logic [ID_W-1:0] node_id,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [3:0]      wr_be,
  input  logic [31:0]     wr_data,
  input  logic            wr_word_irq,
  input  logic [AW-1:0]   rd_addr,
  output logic [31:0]     rd_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [AW-1:0]   tx_addr,
  output logic [31:0]     tx_data,
  output logic            tx_irq,
  output logic            tx_full,
  output logic            tx_not_empty,
  output logic            tx_almost_full,
  input  logic            ret_valid,
  input  logic [ID_W-1:0] ret_src_id,
  input  logic [AW-1:0]   ret_addr
);
  localparam int WORDS   = 2 ** AW;
  localparam int TXW     = AW + WORD_W + 1;
  localparam int WQW     = AW + WORD_W;
  localparam int TXCW    = $clog2(TXQ_DEPTH + 1);
  localparam int WQCW    = $clog2(WQ_DEPTH + 1);
  localparam int AF_LVL  = (TXQ_DEPTH * 7) / 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  word_t mem [WORDS];
  word_t old_word, merged;
  logic  send, irq_tag, defer;
  logic  host_fire, tx_push, tx_pop, wq_push, wq_pop, wq_full, ret_hit;
  logic  mem_we;
  logic [AW-1:0]   mem_waddr;
  word_t           mem_wdata;
  logic [TXW-1:0]  tx_head;
  logic [WQW-1:0]  wq_head;
  logic [TXCW-1:0] tx_cnt;
  logic [WQCW-1:0] wq_cnt;

  assign old_word = mem[wr_addr];
  assign rd_data  = mem[rd_addr];

  rmw_write_eval #(.AW(AW), .LOW_WORDS(LOW_WORDS)) u_eval (
    .addr(wr_addr), .old_word(old_word), .new_data(wr_data), .be(wr_be),
    .filt_en(cfg_filt_en), .filt_low(cfg_filt_low),
    .net_irq_en(cfg_net_irq_en), .irq_override(cfg_irq_override),
    .word_irq(wr_word_irq), .merged(merged), .send(send), .irq(irq_tag)
  );

  always_comb begin
    defer          = (cfg_update_mode == UPD_DEFER);
    tx_full        = (tx_cnt == TXCW'(TXQ_DEPTH));
    tx_not_empty   = (tx_cnt != '0);
    tx_almost_full = (tx_cnt >= TXCW'(AF_LVL));
    wq_full        = (wq_cnt == WQCW'(WQ_DEPTH));
    ret_hit        = ret_valid && (ret_src_id == node_id) && (wq_cnt != '0)
                     && (ret_addr == wq_head[WQW-1 -: AW]);
    wr_ready       = !tx_full && !(defer && wq_full) && !ret_hit;
    host_fire      = wr_valid && wr_ready;
    tx_push        = host_fire && send;
    wq_push        = tx_push && defer;
    wq_pop         = ret_hit;
    tx_valid       = cfg_tx_en && tx_not_empty;
    tx_pop         = tx_valid && tx_ready;
    {tx_addr, tx_data, tx_irq} = tx_head;
    mem_we    = ret_hit || (tx_push && !defer);
    mem_waddr = ret_hit ? wq_head[WQW-1 -: AW] : wr_addr;
    mem_wdata = ret_hit ? wq_head[WORD_W-1:0] : merged;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  rmw_fifo #(.W(TXW), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .push(tx_push), .din({wr_addr, merged, irq_tag}),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt)
  );

  rmw_fifo #(.W(WQW), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_s), .push(wq_push), .din({wr_addr, merged}),
    .pop(wq_pop), .dout(wq_head), .count(wq_cnt)
  );

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    tx_full |-> !wr_ready);
  // R7
  flag_order_chk: assert property (@(posedge clk) disable iff (!rst_s)
    tx_full |-> (tx_almost_full && tx_not_empty));
  // R2
  dropped_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (host_fire && !send && !tx_pop) |=> $stable(tx_cnt));
  // R10
  defer_track_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wq_push |=> (wq_cnt != '0));
  // R12
  track_stall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (defer && wq_full) |-> !wr_ready);
endmodule

// File: tb/rmw_tx_filter_test.sv
module rmw_tx_filter_test;
  localparam int DEPTH = 1024;
  localparam logic [7:0] ME = 8'h2A;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cfg_tx_en, cfg_filt_en, cfg_filt_low, cfg_net_irq_en, cfg_irq_override;
  logic [1:0]  cfg_update_mode;
  logic [7:0]  node_id;
  logic        wr_valid, wr_ready, wr_word_irq;
  logic [10:0] wr_addr, rd_addr, tx_addr, ret_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data, rd_data, tx_data;
  logic        tx_valid, tx_ready, tx_irq, tx_full, tx_not_empty, tx_almost_full;
  logic        ret_valid;
  logic [7:0]  ret_src_id;

  rmw_tx_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_filt_en(cfg_filt_en),
    .cfg_filt_low(cfg_filt_low), .cfg_net_irq_en(cfg_net_irq_en),
    .cfg_irq_override(cfg_irq_override), .cfg_update_mode(cfg_update_mode),
    .node_id(node_id), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_word_irq(wr_word_irq), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
    .tx_data(tx_data), .tx_irq(tx_irq), .tx_full(tx_full), .tx_not_empty(tx_not_empty),
    .tx_almost_full(tx_almost_full), .ret_valid(ret_valid), .ret_src_id(ret_src_id),
    .ret_addr(ret_addr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] ref_mem [int];
  logic [43:0] exp_q [$];
  logic [42:0] pend_q [$];
  logic [43:0] mon_e;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: one compare per message handed over
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected message", {tx_addr, tx_data, tx_irq}, 0);
      end else begin
        mon_e = exp_q.pop_front();
        check({tx_addr, tx_data, tx_irq} == mon_e, "R1 R6 R7 message",
              {tx_addr, tx_data, tx_irq}, mon_e);
      end
    end
  end

  task automatic host_write(input logic [10:0] a, input logic [3:0] be,
                            input logic [31:0] d, input bit wi);
    logic [31:0] oldw, m;
    bit fa, snd, irq;
    @(posedge clk); #2;
    wr_valid = 1; wr_addr = a; wr_be = be; wr_data = d; wr_word_irq = wi;
    do @(negedge clk); while (!wr_ready);
    oldw = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 32'h0;
    m = oldw;
    for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
    fa  = cfg_filt_en && (a >= 11'd1024 || cfg_filt_low);
    snd = !fa || (m != oldw);
    irq = cfg_net_irq_en && (cfg_irq_override || wi);
    if (snd) begin
      exp_q.push_back({a, m, irq});
      if (cfg_update_mode == 2'b11) pend_q.push_back({a, m});
      else ref_mem[int'(a)] = m;
    end
    @(posedge clk); #2;
    wr_valid = 0;
  endtask

  task automatic ring_return(input logic [7:0] id, input logic [10:0] a);
    @(posedge clk); #2;
    ret_valid = 1; ret_src_id = id; ret_addr = a;
    @(negedge clk);
    if (id == ME && pend_q.size() != 0 && pend_q[0][42:32] == a) begin
      ref_mem[int'(a)] = pend_q[0][31:0];
      void'(pend_q.pop_front());
    end
    @(posedge clk); #2;
    ret_valid = 0;
  endtask

  task automatic read_check(input logic [10:0] a, input string req);
    @(posedge clk); #2;
    rd_addr = a;
    @(negedge clk);
    check(rd_data == ref_mem[int'(a)], req, rd_data, ref_mem[int'(a)]);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_tx_en = 1; cfg_filt_en = 0; cfg_filt_low = 0; cfg_net_irq_en = 0;
    cfg_irq_override = 0; cfg_update_mode = 2'b00; node_id = ME;
    wr_valid = 0; wr_addr = 0; wr_be = 0; wr_data = 0; wr_word_irq = 0;
    rd_addr = 0; tx_ready = 1; ret_valid = 0; ret_src_id = 0; ret_addr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check(!tx_valid && !tx_full && !tx_not_empty && !tx_almost_full, "R13 flags",
          {tx_valid, tx_full, tx_not_empty, tx_almost_full}, 0);
    check(wr_ready, "R13 wr_ready", wr_ready, 1);

    // R9 immediate full-word writes, R4 filter off
    host_write(11'd1100, 4'hF, 32'h1111_2222, 0);
    host_write(11'd1101, 4'hF, 32'hDEAD_BEEF, 0);
    host_write(11'd10,   4'hF, 32'h0BAD_F00D, 0);
    read_check(11'd1100, "R9 readback");
    read_check(11'd10, "R9 readback low");
    // R1 partial merges
    host_write(11'd1101, 4'b0001, 32'h0000_0055, 0);
    host_write(11'd1101, 4'b1010, 32'hAB00_CD00, 0);
    read_check(11'd1101, "R1 merged word");
    // R4 same value still sent with filter off
    host_write(11'd1100, 4'hF, 32'h1111_2222, 0);
    drain();
    check(exp_q.size() == 0, "R4 unchanged sent", exp_q.size(), 0);

    // R2 filtering above low region
    cfg_filt_en = 1;
    host_write(11'd1100, 4'hF, 32'h1111_2222, 0);
    host_write(11'd1100, 4'b0100, 32'h0011_0000, 0);
    @(negedge clk);
    check(!tx_not_empty, "R2 suppressed", tx_not_empty, 0);
    host_write(11'd1100, 4'b0100, 32'h0077_0000, 0);
    drain();
    read_check(11'd1100, "R2 changed word stored");

    // R3 low region
    cfg_filt_low = 0;
    host_write(11'd10, 4'hF, 32'h0BAD_F00D, 0);
    drain();
    check(exp_q.size() == 0, "R3 low sent without low enable", exp_q.size(), 0);
    cfg_filt_low = 1;
    host_write(11'd10, 4'hF, 32'h0BAD_F00D, 0);
    @(negedge clk);
    check(!tx_not_empty, "R3 low suppressed", tx_not_empty, 0);
    cfg_filt_en = 0;
    host_write(11'd10, 4'hF, 32'h0BAD_F00D, 0);
    drain();
    cfg_filt_low = 0;

    // R6 interrupt tag combinations
    for (int k = 0; k < 8; k++) begin
      cfg_net_irq_en = k[2]; cfg_irq_override = k[1];
      host_write(11'd1200 + 11'(k), 4'hF, 32'h5000_0000 + k, k[0]);
    end
    drain();
    cfg_net_irq_en = 0; cfg_irq_override = 0;

    // R5 transmit enable holds entries
    cfg_tx_en = 0;
    host_write(11'd1300, 4'hF, 32'hC0DE_0001, 0);
    host_write(11'd1301, 4'hF, 32'hC0DE_0002, 0);
    @(negedge clk);
    check(!tx_valid && tx_not_empty, "R5 held", {tx_valid, tx_not_empty}, 2'b01);
    cfg_tx_en = 1;
    drain();

    // R7 R8 fill the transmit FIFO
    tx_ready = 0;
    for (int i = 0; i < DEPTH; i++) begin
      host_write(11'd1024 + 11'(i), 4'hF, 32'hA000_0000 + i, 0);
      if (i == 894) begin
        @(negedge clk);
        check(!tx_almost_full, "R7 below 7/8", tx_almost_full, 0);
      end
      if (i == 895) begin
        @(negedge clk);
        check(tx_almost_full, "R7 at 7/8", tx_almost_full, 1);
      end
    end
    @(negedge clk);
    check(tx_full && !wr_ready, "R8 full stall", {tx_full, wr_ready}, 2'b10);
    fork
      host_write(11'd1500, 4'hF, 32'hFEED_0001, 0);
      begin
        repeat (5) @(negedge clk);
        check(tx_full && !wr_ready, "R8 still stalled", {tx_full, wr_ready}, 2'b10);
        tx_ready = 1;
      end
    join
    drain();
    check(!tx_not_empty && !tx_full, "R7 drained", {tx_not_empty, tx_full}, 0);

    // R10 R11 deferred update
    cfg_update_mode = 2'b11;
    host_write(11'd1100, 4'hF, 32'h7777_0001, 0);
    host_write(11'd1101, 4'hF, 32'h7777_0002, 0);
    drain();
    read_check(11'd1100, "R10 not yet written");
    ring_return(8'h05, 11'd1100);
    read_check(11'd1100, "R11 foreign id ignored");
    ring_return(ME, 11'd1101);
    read_check(11'd1101, "R11 out of order address ignored");
    ring_return(ME, 11'd1100);
    read_check(11'd1100, "R10 first completes");
    ring_return(ME, 11'd1101);
    read_check(11'd1101, "R10 second completes");

    // R12 tracking queue full
    for (int j = 0; j < 4; j++) host_write(11'd1400 + 11'(j), 4'hF, 32'h9000_0000 + j, 0);
    drain();
    check(!wr_ready, "R12 stall when tracking full", wr_ready, 0);
    ring_return(ME, 11'd1400);
    @(negedge clk);
    check(wr_ready, "R12 slot freed", wr_ready, 1);
    read_check(11'd1400, "R10 tracked word written");
    for (int j = 1; j < 4; j++) ring_return(ME, 11'd1400 + 11'(j));
    read_check(11'd1403, "R10 last tracked word");
    cfg_update_mode = 2'b00;

    drain();
    check(exp_q.size() == 0, "R7 all messages seen", exp_q.size(), 0);
    finish_run();
  end
endmodule